// File: doc/BRIEF.md
# Shared-Bus Serial Transmitter with Collision Back-Off

This block sends bytes one at a time onto a single serial line that several stations share. The line is wired-AND: a station pulls it low to send a zero, and releases it to send a one, so a pull-up resistor makes it high. Any station that sends a zero therefore overrides every station that sends a one. A byte arrives through a valid/ready handshake. The block waits until the bus-busy input is low. It then waits a further pseudo-random number of bit periods, counted from the moment the bus went idle, and only then starts the frame.

While a frame goes out, the block reads the line back through a two-flop synchronizer. Near the middle of every bit except the stop bit, it compares the level it reads with the level it meant to send. On a mismatch it loses the contest. It releases the line at once, pulses a collision flag for one cycle, draws a fresh random delay and later resends the same byte from its start bit. A station that wins the contest sees no mismatch and simply carries on. A one-cycle done pulse marks the end of a frame that went through.

Bit timing comes from an external tick (a clock enable, nominally 2 MHz): each bit lasts eight ticks, which gives 250 kbit/s.

Top module: `sbus_tx`

## Requirements
- R1: After a synchronous active-low reset, line_drive_n is 1, in_ready is 1, done is 0 and collision is 0.
- R2: An 8-bit LFSR starts at 0x01 and shifts every clock: the new value is {old[6:0], old[7]^old[5]^old[4]^old[3]}. The wait in ticks is ((lfsr & 7) + 1) * 8, taken from the LFSR value at the loading edge. The wait is loaded when a byte is accepted, on a collision abort, and on every clock in which bus_busy is high during the wait. When the bus stays idle, the start bit begins at the clock edge of the tick that ends the wait.
- R3: While bus_busy is high during the wait, the block never starts a frame and never pulls the line low.
- R4: A frame is a start bit (0), then the 8 data bits least significant first, then a stop bit (1). Each bit lasts 8 ticks. line_drive_n is 0 exactly while a 0 bit is being sent, and is 1 at all other times.
- R5: in_ready is 1 only while the block holds no byte. A byte is taken on a clock where in_valid and in_ready are both 1.
- R6: At the tick that ends the 4th tick period of each bit (the in-bit tick count goes from 3 to 4), the synchronized readback is compared with the bit being sent. A mismatch in the start bit or any data bit ends the frame. On the next cycle line_drive_n is 1 and collision is 1 for exactly one cycle.
- R7: The stop bit is never compared. A low level on the line during the stop bit does not cause a collision.
- R8: After a collision, in_ready stays 0 and the same byte is sent again from its start bit after a new random wait.
- R9: done is 1 for one cycle after the last tick of the stop bit, and in_ready is 1 in that same cycle.
- R10: bus_busy has no effect once a frame has started.
- R11: Another station pulling the line low while this block sends a 0 is not a collision, and the frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_tick | input | 1 | One-cycle clock enable, 8 per bit period |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data holds a byte to send |
| in_ready | output | 1 | The block can take a byte |
| bus_busy | input | 1 | Another transfer occupies the bus |
| line_in | input | 1 | Raw level read back from the shared line |
| line_drive_n | output | 1 | 0 pulls the line low, 1 releases it |
| done | output | 1 | One-cycle pulse when a frame completes |
| collision | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
The bench models a second station that pulls the line low during a chosen bit. It places that pull on a one bit (which must abort), on a zero bit (which must not) and on the stop bit (which must be ignored). A design that compared the stop bit would abort frames that had already gone through. A design that did not reload the frame on abort would resend from the middle of the byte, which the count of low cycles exposes. The bench also counts ticks from acceptance to the start bit against its own LFSR. It holds bus_busy through the wait and toggles it during a frame: a design that ignored the busy signal would drive the line early, and one that watched it while sending would stall or abort.

// File: rtl/sbtx_pkg.sv
// Shared types for the shared-bus transmitter.
package sbtx_pkg;
    // Controller phase: holding no byte, backing off, or shifting a frame
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_WAIT = 2'd1,
        TX_SEND = 2'd2
    } tx_state_t;
endpackage

// File: rtl/sbtx_sync2.sv
// Two-flop synchronizer for the raw line readback.
// Assumes: d is asynchronous to clk; the reset value matches an idle (released) line.
module sbtx_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Two-stage capture of the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sbtx_lfsr.sv
// Free-running Fibonacci LFSR that gives the back-off random value.
// Assumes: TAPS gives a maximal sequence and SEED is nonzero; only the low OUT_W bits leave.
module sbtx_lfsr #(
    parameter int          W     = 8,
    parameter int          OUT_W = 3,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] lfsr;

    // Shift every clock, the feedback bit is the parity of the tapped bits
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= SEED;
        else        lfsr <= {lfsr[W-2:0], ^(lfsr & TAPS)};
    end

    assign rnd = lfsr[OUT_W-1:0];

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
endmodule

// File: rtl/sbtx_backoff.sv
// Random back-off counter, measured in ticks from the last busy cycle.
// Assumes: load and active are never high together; expire is meaningful only while active.
module sbtx_backoff #(
    parameter int TPB   = 8,
    parameter int RND_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             active,
    input  logic             busy,
    input  logic             tick,
    input  logic [RND_W-1:0] rnd,
    output logic             expire
);
    localparam int CW = $clog2((2**RND_W) * TPB + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    // Whole number of bit periods, from 1 up to 2**RND_W
    assign reload = (CW'(rnd) + CW'(1)) * CW'(TPB);

    // Reload on a new attempt or while busy, otherwise count ticks down
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (load || (active && busy)) cnt <= reload;
        else if (active && tick && cnt != '0) cnt <= cnt - CW'(1);
    end

    assign expire = active && !busy && tick && (cnt == CW'(1));

    // R3
    backoff_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && busy) |=> (cnt >= CW'(TPB)));
endmodule

// File: rtl/sbus_tx.sv
// Collision-aware transmitter for a wired-AND shared serial line.
// Frame: start 0, DATA_W bits LSB first, stop 1, each bit TPB ticks of samp_tick.
// Assumes: samp_tick is a one-cycle pulse and line_in is the raw shared-line level.
module sbus_tx
    import sbtx_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          TPB       = 8,
    parameter int          SAMPLE_AT = TPB/2 - 1,
    parameter int          RND_W     = 3,
    parameter int          LFSR_W    = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              bus_busy,
    input  logic              line_in,
    output logic              line_drive_n,
    output logic              done,
    output logic              collision
);
    localparam int FW = DATA_W + 2;
    localparam int IW = $clog2(FW);
    localparam int TW = $clog2(TPB);
    localparam logic [IW-1:0] STOP_IDX = IW'(FW - 1);

    tx_state_t         state;
    logic [DATA_W-1:0] held;
    logic [FW-1:0]     frame;
    logic [IW-1:0]     idx;
    logic [TW-1:0]     tcnt;
    logic              line_s;
    logic [RND_W-1:0]  rnd;
    logic              go;
    logic              accept;
    logic              abort;
    logic              load;

    sbtx_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
    );

    sbtx_lfsr #(.W(LFSR_W), .OUT_W(RND_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    sbtx_backoff #(.TPB(TPB), .RND_W(RND_W)) u_backoff (
        .clk(clk), .rst_n(rst_n), .load(load), .active(state == TX_WAIT),
        .busy(bus_busy), .tick(samp_tick), .rnd(rnd), .expire(go)
    );

    // Handshake and abort decisions for this cycle
    assign accept = (state == TX_IDLE) && in_valid;
    assign abort  = (state == TX_SEND) && samp_tick && (tcnt == TW'(SAMPLE_AT))
                    && (idx != STOP_IDX) && (line_s != frame[0]);
    assign load   = accept || abort;

    // Phase control, bit timing and frame shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            held      <= '0;
            frame     <= '1;
            idx       <= '0;
            tcnt      <= '0;
            done      <= 1'b0;
            collision <= 1'b0;
        end else begin
            done      <= 1'b0;
            collision <= 1'b0;
            unique case (state)
                TX_IDLE: if (accept) begin
                    held  <= in_data;
                    frame <= {1'b1, in_data, 1'b0};
                    state <= TX_WAIT;
                end
                TX_WAIT: if (go) begin
                    state <= TX_SEND;
                    idx   <= '0;
                    tcnt  <= '0;
                end
                TX_SEND: if (abort) begin
                    state     <= TX_WAIT;
                    frame     <= {1'b1, held, 1'b0};
                    collision <= 1'b1;
                end else if (samp_tick) begin
                    if (tcnt == TW'(TPB - 1)) begin
                        tcnt <= '0;
                        if (idx == STOP_IDX) begin
                            state <= TX_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx   <= idx + IW'(1);
                            frame <= {1'b1, frame[FW-1:1]};
                        end
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Outputs that follow the registered phase
    assign in_ready     = (state == TX_IDLE);
    assign line_drive_n = !((state == TX_SEND) && !frame[0]);

    // R6
    coll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> line_drive_n);
    // R6
    coll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> !collision);
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_WAIT && bus_busy) |=> (state != TX_SEND));
    // R4
    drive_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SEND && !samp_tick) |=> $stable(line_drive_n));
    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);
    // R8
    coll_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> !in_ready);
endmodule

// File: tb/sim_sbus_tx.sv
module sim_sbus_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_tick = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       bus_busy = 1'b0;
    logic       oth_n = 1'b1;
    logic       in_ready, line_drive_n, done, collision;
    logic       line_in;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    assign line_in = line_drive_n & oth_n;

    sbus_tx u0 (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .bus_busy(bus_busy),
        .line_in(line_in), .line_drive_n(line_drive_n), .done(done),
        .collision(collision)
    );

    always #4 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int         m_mode = 0;          // 0 idle, 1 waiting, 2 sending
    int         m_wcnt = 0, m_tcnt = 0, m_idx = 0;
    logic [9:0] m_frame = '1;
    logic [7:0] m_held = '0, m_lfsr = 8'h01;
    logic       m_s1 = 1'b1, m_s2 = 1'b1, m_done = 1'b0, m_coll = 1'b0;
    int         tick_total = 0;

    function automatic logic m_drive();
        return !(m_mode == 2 && m_frame[0] == 1'b0);
    endfunction

    always @(posedge clk) begin
        logic line;
        int   rel;
        if (samp_tick) tick_total++;
        if (!rst_n) begin
            m_mode = 0; m_wcnt = 0; m_tcnt = 0; m_idx = 0; m_frame = '1; m_held = '0;
            m_lfsr = 8'h01; m_s1 = 1; m_s2 = 1; m_done = 0; m_coll = 0;
        end else begin
            line = m_drive() & oth_n;
            rel  = ((m_lfsr & 8'h07) + 1) * 8;
            m_done = 0; m_coll = 0;
            if (m_mode == 0) begin
                if (in_valid) begin
                    m_held = in_data; m_frame = {1'b1, in_data, 1'b0};
                    m_mode = 1; m_wcnt = rel;
                end
            end else if (m_mode == 1) begin
                if (bus_busy) m_wcnt = rel;
                else if (samp_tick) begin
                    if (m_wcnt == 1) begin m_mode = 2; m_tcnt = 0; m_idx = 0; end
                    else m_wcnt--;
                end
            end else if (samp_tick) begin
                if (m_tcnt == 3 && m_idx != 9 && m_s2 != m_frame[0]) begin
                    m_mode = 1; m_wcnt = rel; m_coll = 1; m_frame = {1'b1, m_held, 1'b0};
                end else if (m_tcnt == 7) begin
                    m_tcnt = 0;
                    if (m_idx == 9) begin m_mode = 0; m_done = 1; end
                    else begin m_idx++; m_frame = {1'b1, m_frame[9:1]}; end
                end else m_tcnt++;
            end
            m_s2 = m_s1; m_s1 = line;
            m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // other station and tick stimulus, driven away from the active edge
    int   tdiv = 0;
    logic inj_arm = 1'b0;
    int   inj_idx = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        samp_tick <= (tdiv == 3);
        if (m_coll) inj_arm = 1'b0;
        oth_n <= !(inj_arm && m_mode == 2 && m_idx == inj_idx);
    end

    // per-cycle comparison and event monitors
    int low_cnt = 0, low_busy = 0, coll_cnt = 0, done_cnt = 0, viol = 0;
    logic pend = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R4 drive", int'(line_drive_n), int'(m_drive()));
            chk("R5 ready", int'(in_ready), int'(m_mode == 0));
            chk("R9 done", int'(done), int'(m_done));
            chk("R6 collision", int'(collision), int'(m_coll));
            if (!line_drive_n) low_cnt++;
            if (!line_drive_n && bus_busy) low_busy++;
            if (collision) begin coll_cnt++; pend = 1'b1; end
            if (done) begin done_cnt++; pend = 1'b0; end
            else if (pend && in_ready) viol++;
        end
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic clr();
        low_cnt = 0; low_busy = 0; coll_cnt = 0; done_cnt = 0; viol = 0;
    endtask

    logic [7:0] lf_at;
    int         t0;
    task automatic send(input logic [7:0] b);
        while (m_mode != 0) @(negedge clk);
        in_data = b; in_valid = 1'b1; lf_at = m_lfsr;
        @(negedge clk);
        in_valid = 1'b0; t0 = tick_total;
    endtask

    task automatic wait_done(input int n);
        for (int i = 0; i < 4000 && done_cnt < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 drive", int'(line_drive_n), 1);
        chk("R1 ready", int'(in_ready), 1);
        chk("R1 done", int'(done), 0);
        chk("R1 collision", int'(collision), 0);

        // R2 / R4: clean frame of 0xA5 (5 zero bits: 5*8 ticks*4 clocks = 160)
        clr();
        send(8'hA5);
        for (int i = 0; i < 2000 && line_drive_n; i++) @(negedge clk);
        chk("R2 wait ticks", tick_total - t0, ((int'(lf_at) & 7) + 1) * 8);
        wait_done(1);
        chk("R4 low cycles", low_cnt, 160);
        chk("R9 done count", done_cnt, 1);

        // R3: busy held through the wait
        clr();
        bus_busy = 1'b1;
        send(8'h00);
        repeat (300) @(negedge clk);
        chk("R3 no low while busy", low_busy, 0);
        chk("R3 no frame while busy", low_cnt, 0);
        bus_busy = 1'b0;
        wait_done(1);
        chk("R3 frame after idle", done_cnt, 1);

        // R6 / R8: lose on data bit 2 (bit index 3) of 0xFF, then resend
        clr();
        inj_idx = 3; inj_arm = 1'b1;
        send(8'hFF);
        wait_done(1);
        chk("R6 collision count", coll_cnt, 1);
        chk("R8 ready held low", viol, 0);
        chk("R8 resent from start", low_cnt, 64);
        chk("R8 done after retry", done_cnt, 1);

        // R11: other station low while this one sends zeros
        clr();
        inj_idx = 2; inj_arm = 1'b1;
        send(8'h00);
        wait_done(1);
        inj_arm = 1'b0;
        chk("R11 no collision", coll_cnt, 0);
        chk("R11 done", done_cnt, 1);

        // R7: other station low during the stop bit
        clr();
        inj_idx = 9; inj_arm = 1'b1;
        send(8'h3C);
        wait_done(1);
        inj_arm = 1'b0;
        chk("R7 no collision", coll_cnt, 0);
        chk("R7 done", done_cnt, 1);

        // R10: busy toggling during a frame of 0x5A (4 zero data bits -> 160)
        clr();
        send(8'h5A);
        for (int i = 0; i < 2000 && line_drive_n; i++) @(negedge clk);
        for (int i = 0; i < 4000 && done_cnt < 1; i++) begin
            bus_busy = (i % 7) < 3;
            @(negedge clk);
        end
        bus_busy = 1'b0;
        chk("R10 no collision", coll_cnt, 0);
        chk("R10 done", done_cnt, 1);
        chk("R10 frame intact", low_cnt, 160);

        // R5: back-to-back bytes
        clr();
        send(8'h12); send(8'h34); send(8'h56);
        wait_done(3);
        chk("R5 three frames", done_cnt, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule